// File: doc/BRIEF.md
# CD-ROM Sector Sync Detector and Descrambler

This block takes a byte stream of raw CD-ROM sectors and finds where each sector begins by looking for the 12-byte sync pattern. The pattern is a zero byte, ten bytes of 0xFF, then a zero byte. Once it has found a sync it holds sector alignment. The sector length is a parameter and defaults to 2352 bytes. If a later sync is damaged, the block writes a clean pattern in its place and keeps counting (flywheel). It only gives up the alignment after a configurable number of misses in a row. Every byte after the sync is descrambled with the standard 15-bit scrambler sequence.

While a sector streams through, the block reads three bytes after descrambling: the header mode byte and the two copies of the subheader submode. From these it classifies the sector. At the last byte of each sector it reports the class together with a flag that says whether that sector's sync had to be inserted. Error correction, error detection and buffering are left to later stages.

Top module: `cdrom_sector_sync`

## Requirements
- R1: While searching, the block produces no output bytes. When the byte completing the pattern 00,FF×10,00 is accepted, `locked` is high from the next cycle, and that sync is not emitted.
- R2: Once locked, each accepted byte is assigned a sector offset. The byte after the sync is offset 12, the offsets wrap from SECTOR_LEN-1 to 0, `out_sof` marks offset 0, and each output appears one cycle after its byte is accepted.
- R3: A byte at offset k ≥ 12 is output as the input XOR a key byte. The key comes from a 15-bit LFSR (x^15+x+1, seed 0x0001) that restarts for every sector. Bits are taken LSB first, from bit 0 of the register. The first two key bytes are 0x01 and 0x80.
- R4: When locked, offsets 0 to 11 are output as the ideal sync pattern whatever the input bytes were.
- R5: A mismatched sync at offset 11 while locked keeps the lock and alignment, and sets `sec_inserted`=1 for that sector. A sync pattern elsewhere in the data while locked has no effect on alignment.
- R6: After MISS_LIMIT (default 3) consecutive missed syncs, `locked` falls and the byte at offset 11 is not output. A matching sync clears the miss count.
- R7: `sec_mode` codes are: 0 for header byte 0x00, 1 for 0x01, 2, 3 or 4 for 0x02 (see R8), and 7 for any other value. Header byte at offset 15, values after descrambling.
- R8: For header 0x02, the submode byte is at offset 18 and its copy at offset 22. If the two agree, the form comes from bit 5 of the submode: code 3 for form 1 (bit 5 = 0), code 4 for form 2 (bit 5 = 1). If they differ, the code is 2.
- R9: `sec_done` pulses together with the output of offset SECTOR_LEN-1. `sec_mode` and `sec_inserted` change only at that pulse and hold otherwise.
- R10: A cycle with `in_valid` low produces no output and changes neither alignment nor lock.
- R11: After reset, `locked`, `out_valid`, `out_sof`, `sec_done` and `sec_inserted` are 0 and `sec_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Raw scrambled stream byte |
| out_valid | output | 1 | Output byte is present |
| out_byte | output | 8 | Descrambled byte or inserted sync byte |
| out_sof | output | 1 | Output byte is sector offset 0 |
| locked | output | 1 | Sector alignment held |
| sec_done | output | 1 | Last byte of a sector is on the output |
| sec_inserted | output | 1 | Sync of the finished sector was inserted |
| sec_mode | output | 3 | Class of the finished sector |

## Verification
The bench damages single syncs and checks that the lock holds, that the inserted flag is set and that the pattern bytes are rewritten. A design that dropped the lock at once, or that re-aligned on a fake pattern placed inside the data, would shift every later offset and corrupt the descrambled stream. A run of misses is interleaved with good syncs to show that the miss count clears. Three misses in a row must give up the lock: a design that failed to give up would flywheel forever. Mode 2 sectors with agreeing and disagreeing submode copies catch a design that reads the form bit from the wrong byte or without descrambling it. Idle gaps fall at random between bytes, so a design that advanced the offset or the LFSR on idle cycles would lose step with the key sequence.

// File: rtl/cdsync_pkg.sv
package cdsync_pkg;

    localparam int SYNC_BYTES = 12;
    localparam int SCR_BITS   = 15;
    localparam logic [SCR_BITS-1:0] SCR_SEED = 15'h0001;

    typedef enum logic [2:0] {
        MD_0   = 3'd0,
        MD_1   = 3'd1,
        MD_2   = 3'd2,
        MD_2F1 = 3'd3,
        MD_2F2 = 3'd4,
        MD_BAD = 3'd7
    } sect_mode_e;

    // ideal sync byte at position idx of the pattern
    function automatic logic [7:0] sync_byte(input int idx);
        return (idx == 0 || idx == SYNC_BYTES - 1) ? 8'h00 : 8'hFF;
    endfunction

    // eight steps of x^15+x+1, LSB out first: {next_state, key}
    function automatic logic [SCR_BITS+7:0] scr_step8(input logic [SCR_BITS-1:0] st);
        logic [SCR_BITS-1:0] s;
        logic [7:0]          k;
        s = st;
        k = '0;
        for (int i = 0; i < 8; i++) begin
            k[i] = s[0];
            s    = {s[0] ^ s[1], s[SCR_BITS-1:1]};
        end
        return {s, k};
    endfunction

    function automatic sect_mode_e classify(input logic [7:0] hdr,
                                            input logic [7:0] sub,
                                            input logic [7:0] sub_cpy);
        case (hdr)
            8'h00:   return MD_0;
            8'h01:   return MD_1;
            8'h02: begin
                if (sub != sub_cpy) return MD_2;
                return sub[5] ? MD_2F2 : MD_2F1;
            end
            default: return MD_BAD;
        endcase
    endfunction

endpackage

// File: rtl/cdsync_window.sv
module cdsync_window
    import cdsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_i,
    input  logic [7:0] byte_i,
    output logic       match_o
);
    localparam int HIST_W = (SYNC_BYTES - 1) * 8;
    localparam int FULL_W = SYNC_BYTES * 8;

    logic [HIST_W-1:0] hist_q;
    logic [FULL_W-1:0] full;

    assign full = {hist_q, byte_i};

    always_comb begin
        match_o = 1'b1;
        for (int k = 0; k < SYNC_BYTES; k++) begin
            if (full[(SYNC_BYTES-1-k)*8 +: 8] != sync_byte(k)) match_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       hist_q <= '0;
        else if (shift_i) hist_q <= full[HIST_W-1:0];
    end
endmodule

// File: rtl/cdsync_scrambler.sv
module cdsync_scrambler
    import cdsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       adv_i,
    output logic [7:0] key_o
);
    logic [SCR_BITS-1:0] st_q;
    logic [SCR_BITS+7:0] nxt;

    assign nxt   = scr_step8(st_q);
    assign key_o = nxt[7:0];

    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= SCR_SEED;
        else if (load_i) st_q <= SCR_SEED;
        else if (adv_i)  st_q <= nxt[SCR_BITS+7:8];
    end
endmodule

// File: rtl/cdrom_sector_sync.sv
module cdrom_sector_sync
    import cdsync_pkg::*;
#(
    parameter int SECTOR_LEN = 2352,
    parameter int MISS_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_sof,
    output logic       locked,
    output logic       sec_done,
    output logic       sec_inserted,
    output logic [2:0] sec_mode
);
    localparam int POS_W  = $clog2(SECTOR_LEN);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [POS_W-1:0]  OFF_LAST = POS_W'(SECTOR_LEN - 1);
    localparam logic [POS_W-1:0]  OFF_SYNC = POS_W'(SYNC_BYTES - 1);
    localparam logic [POS_W-1:0]  OFF_HDR  = POS_W'(15);
    localparam logic [POS_W-1:0]  OFF_SUB  = POS_W'(18);
    localparam logic [POS_W-1:0]  OFF_SUBC = POS_W'(22);
    localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(MISS_LIMIT);

    typedef struct packed {
        logic              locked;
        logic [POS_W-1:0]  pos;
        logic [MISS_W-1:0] miss;
        logic [7:0]        hdr;
        logic [7:0]        sub;
        logic [7:0]        sub_cpy;
        logic              ins;
        logic              out_valid;
        logic [7:0]        out_byte;
        logic              out_sof;
        logic              sec_done;
        logic              sec_ins;
        sect_mode_e        sec_mode;
    } state_t;

    state_t d, q;

    logic             match;
    logic [7:0]       key;
    logic [POS_W-1:0] cur_off;
    logic             load_key;
    logic             adv_key;

    assign cur_off  = (q.pos == OFF_LAST) ? '0 : q.pos + POS_W'(1);
    assign load_key = in_valid && (q.locked ? (cur_off == OFF_SYNC) : match);
    assign adv_key  = in_valid && q.locked && (cur_off > OFF_SYNC);

    cdsync_window u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (in_valid),
        .byte_i  (in_byte),
        .match_o (match)
    );

    cdsync_scrambler u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_key),
        .adv_i  (adv_key),
        .key_o  (key)
    );

    always_comb begin
        logic [7:0]        ob;
        logic              lost;
        logic [MISS_W-1:0] miss_inc;
        d           = q;
        d.out_valid = 1'b0;
        d.out_sof   = 1'b0;
        d.sec_done  = 1'b0;
        ob          = 8'h00;
        lost        = 1'b0;
        miss_inc    = q.miss + MISS_W'(1);
        if (in_valid) begin
            if (!q.locked) begin
                if (match) begin
                    d.locked = 1'b1;
                    d.pos    = OFF_SYNC;
                    d.miss   = '0;
                    d.ins    = 1'b0;
                end
            end else begin
                d.pos = cur_off;
                if (cur_off <= OFF_SYNC) begin
                    ob = sync_byte(int'(cur_off));
                    if (cur_off == OFF_SYNC) begin
                        if (match) begin
                            d.miss = '0;
                            d.ins  = 1'b0;
                        end else begin
                            d.ins = 1'b1;
                            if (miss_inc == MISS_MAX) begin
                                lost     = 1'b1;
                                d.locked = 1'b0;
                                d.miss   = '0;
                            end else begin
                                d.miss = miss_inc;
                            end
                        end
                    end
                end else begin
                    ob = in_byte ^ key;
                    if (cur_off == OFF_HDR)  d.hdr     = ob;
                    if (cur_off == OFF_SUB)  d.sub     = ob;
                    if (cur_off == OFF_SUBC) d.sub_cpy = ob;
                end
                d.out_valid = !lost;
                d.out_byte  = ob;
                d.out_sof   = (cur_off == '0);
                if (cur_off == OFF_LAST) begin
                    d.sec_done = 1'b1;
                    d.sec_ins  = q.ins;
                    d.sec_mode = classify(q.hdr, q.sub, q.sub_cpy);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.sec_mode <= MD_0;
        end else begin
            q <= d;
        end
    end

    assign out_valid    = q.out_valid;
    assign out_byte     = q.out_byte;
    assign out_sof      = q.out_sof;
    assign locked       = q.locked;
    assign sec_done     = q.sec_done;
    assign sec_inserted = q.sec_ins;
    assign sec_mode     = q.sec_mode;
endmodule

// File: rtl/cdrom_sector_sync_chk.sv
module cdrom_sector_sync_chk #(
    parameter int SECTOR_LEN = 2352
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       out_sof,
    input logic       locked,
    input logic       sec_done,
    input logic       sec_inserted,
    input logic [2:0] sec_mode
);
    localparam int POS_W = $clog2(SECTOR_LEN);

    logic             seen_q;
    logic [POS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!locked) begin
            seen_q <= 1'b0;
        end else if (out_valid) begin
            if (out_sof) begin
                seen_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + POS_W'(1);
            end
        end
    end

    AST_NO_OUT_WHEN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(locked)); // R1
    AST_LOCK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_valid)); // R1
    AST_SOF_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid); // R2
    AST_SECTOR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        sec_done |-> (!seen_q || cnt_q == POS_W'(SECTOR_LEN - 2))); // R2
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sec_mode <= 3'd4 || sec_mode == 3'd7); // R7
    AST_DONE_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        sec_done |-> (out_valid && !out_sof)); // R9
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_done |-> $stable({sec_mode, sec_inserted})); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_IDLE_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(locked)); // R10
endmodule

bind cdrom_sector_sync cdrom_sector_sync_chk #(.SECTOR_LEN(SECTOR_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_sof      (out_sof),
    .locked       (locked),
    .sec_done     (sec_done),
    .sec_inserted (sec_inserted),
    .sec_mode     (sec_mode)
);

// File: tb/cdrom_sector_sync_bench.sv
module cdrom_sector_sync_bench;
    localparam int L   = 2352;
    localparam int LIM = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, out_sof, locked, sec_done, sec_inserted;
    logic [7:0] out_byte;
    logic [2:0] sec_mode;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    byte unsigned scr [L-12];

    // model state
    bit        m_lock = 0;
    int        m_pos = 0;
    int        m_miss = 0;
    bit        m_ins = 0;
    bit [7:0]  m_hdr = 0, m_sub = 0, m_subc = 0;
    bit [87:0] hist = '0;
    bit        e_valid = 0, e_sof = 0, e_done = 0, e_ins = 0;
    bit [7:0]  e_byte = 0;
    bit [2:0]  e_mode = 0;
    int        e_off = 0;

    always #5 clk = ~clk;

    cdrom_sector_sync #(.SECTOR_LEN(L), .MISS_LIMIT(LIM)) u_cdrom_sector_sync (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
        .locked(locked), .sec_done(sec_done), .sec_inserted(sec_inserted),
        .sec_mode(sec_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] pat(input int i);
        return (i == 0 || i == 11) ? 8'h00 : 8'hFF;
    endfunction

    function automatic bit [2:0] cls(input bit [7:0] h, input bit [7:0] s, input bit [7:0] c);
        if (h == 8'h00) return 3'd0;
        if (h == 8'h01) return 3'd1;
        if (h != 8'h02) return 3'd7;
        if (s != c) return 3'd2;
        return s[5] ? 3'd4 : 3'd3;
    endfunction

    task automatic model(input bit v, input bit [7:0] b);
        bit match, lost;
        int off;
        bit [7:0] ob;
        e_valid = 0; e_sof = 0; e_done = 0;
        if (!v) return;
        match = 1;
        for (int i = 0; i < 11; i++) if (hist[(10-i)*8 +: 8] != pat(i)) match = 0;
        if (b != 8'h00) match = 0;
        if (!m_lock) begin
            if (match) begin m_lock = 1; m_pos = 11; m_miss = 0; m_ins = 0; end
        end else begin
            off = (m_pos == L-1) ? 0 : m_pos + 1;
            m_pos = off; lost = 0;
            if (off < 12) begin
                ob = pat(off);
                if (off == 11) begin
                    if (match) begin m_miss = 0; m_ins = 0; end
                    else begin
                        m_ins = 1;
                        if (m_miss + 1 == LIM) begin lost = 1; m_lock = 0; m_miss = 0; end
                        else m_miss++;
                    end
                end
            end else begin
                ob = b ^ scr[off-12];
                if (off == 15) m_hdr = ob;
                if (off == 18) m_sub = ob;
                if (off == 22) m_subc = ob;
            end
            e_valid = !lost; e_byte = ob; e_sof = (off == 0); e_off = off;
            if (off == L-1) begin e_done = 1; e_ins = m_ins; e_mode = cls(m_hdr, m_sub, m_subc); end
        end
        hist = {hist[79:0], b};
    endtask

    task automatic cyc(input bit v, input bit [7:0] b);
        @(negedge clk);
        in_valid = v; in_byte = b;
        model(v, b);
        @(posedge clk); #1;
        chk(out_valid == e_valid, v ? "R2 out_valid" : "R10 idle out_valid", out_valid, e_valid);
        chk(locked == m_lock, "R1/R6 locked", locked, m_lock);
        chk(sec_done == e_done, "R9 sec_done", sec_done, e_done);
        if (e_valid) begin
            chk(out_byte == e_byte, (e_off < 12) ? "R4 sync byte" : "R3 descrambled byte", out_byte, e_byte);
            chk(out_sof == e_sof, "R2 out_sof", out_sof, e_sof);
        end
        chk(sec_mode == e_mode, "R7 sec_mode", sec_mode, e_mode);
        chk(sec_inserted == e_ins, "R5 sec_inserted", sec_inserted, e_ins);
    endtask

    task automatic byte_gap(input bit [7:0] b);
        if ($urandom_range(7) == 0) cyc(1'b0, 8'h00);
        cyc(1'b1, b);
    endtask

    task automatic sector(input bit [7:0] hdr, input bit [7:0] s18, input bit [7:0] s22,
                          input bit bad, input bit fake);
        bit [7:0] p;
        for (int o = 0; o < L; o++) begin
            if (o < 12) begin
                p = pat(o);
                if (bad && o == 5) p = 8'h7E;
            end else begin
                p = 8'($urandom);
                if (o == 15) p = hdr;
                if (o == 18) p = s18;
                if (o == 22) p = s22;
                if (o == 12) p = 8'h00;
                if (o == 13) p = 8'h00;
                p = p ^ scr[o-12];
                if (fake && o >= 200 && o < 212) p = pat(o - 200);
            end
            byte_gap(p);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        int s;
        bit [14:0] r;
        r = 15'h0001;
        for (int k = 0; k < L-12; k++) begin
            bit [7:0] kb;
            for (int i = 0; i < 8; i++) begin
                kb[i] = r[0];
                r = {r[0] ^ r[1], r[14:1]};
            end
            scr[k] = kb;
        end
        s = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        chk(locked == 0 && out_valid == 0 && out_sof == 0, "R11 reset flags", {locked, out_valid, out_sof}, 0);
        chk(sec_done == 0 && sec_inserted == 0 && sec_mode == 0, "R11 reset status", {sec_done, sec_inserted, sec_mode}, 0);
        rst_n = 1'b1;
        chk(scr[0] == 8'h01 && scr[1] == 8'h80, "R3 key start", {scr[0], scr[1]}, 16'h0180);
        for (int i = 0; i < 40; i++) cyc(1'b1, 8'h01 + 8'($urandom_range(200)));
        sector(8'h01, 8'h00, 8'h00, 0, 0);
        chk(sec_mode == 3'd1, "R7 mode 1", sec_mode, 1);
        sector(8'h00, 8'h00, 8'h00, 0, 0);
        chk(sec_mode == 3'd0, "R7 mode 0", sec_mode, 0);
        sector(8'h02, 8'h20, 8'h20, 0, 0);
        chk(sec_mode == 3'd4, "R8 form 2", sec_mode, 4);
        sector(8'h02, 8'h08, 8'h08, 0, 0);
        chk(sec_mode == 3'd3, "R8 form 1", sec_mode, 3);
        sector(8'h02, 8'h20, 8'h00, 0, 0);
        chk(sec_mode == 3'd2, "R8 plain mode 2", sec_mode, 2);
        sector(8'h09, 8'h00, 8'h00, 1, 1);
        chk(sec_mode == 3'd7 && sec_inserted == 1, "R5 inserted, other header",
            {sec_inserted, sec_mode}, 4'hF);
        chk(locked == 1, "R5 lock kept", locked, 1);
        sector(8'h01, 8'h00, 8'h00, 0, 0);
        chk(sec_inserted == 0, "R5 clean sync", sec_inserted, 0);
        sector(8'h01, 8'h00, 8'h00, 1, 0);
        sector(8'h01, 8'h00, 8'h00, 1, 0);
        chk(locked == 1, "R6 two misses keep lock", locked, 1);
        sector(8'h01, 8'h00, 8'h00, 1, 0);
        chk(locked == 0, "R6 lock lost", locked, 0);
        sector(8'h02, 8'h20, 8'h20, 0, 0);
        sector(8'h01, 8'h00, 8'h00, 1, 0);
        sector(8'h01, 8'h00, 8'h00, 0, 0);
        sector(8'h01, 8'h00, 8'h00, 1, 0);
        sector(8'h00, 8'h00, 8'h00, 1, 0);
        chk(locked == 1, "R6 count cleared by good sync", locked, 1);
        for (int i = 0; i < 20; i++) cyc(1'b0, 8'h00);
        chk(locked == 1, "R10 idle keeps lock", locked, 1);
        for (int n = 0; n < 5; n++) begin
            bit [7:0] h, a, b;
            h = 8'($urandom_range(3));
            a = 8'($urandom);
            b = ($urandom_range(1) == 0) ? a : 8'($urandom);
            sector(h, a, b, $urandom_range(3) == 0, 0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule